// File: doc/BRIEF.md
# Quadrature Down-Mixer for Real IF Samples

The block takes a stream of real signed samples from an ADC sitting at an intermediate frequency of one eighth of the sample rate. For every accepted sample it returns an in-phase and a quadrature value, which moves the spectrum to baseband. The local oscillator is a 3-bit phase counter. It steps by 45 degrees on each accepted sample, so the oscillator phase is tied to the sample index and not to the clock.

There are no multipliers and no sine table. The sample is placed on the real axis as the vector (s, 0). A quarter-turn pre-rotation moves it first, and a pipelined CORDIC in rotation mode then turns it through the remaining angle, one iteration per stage. The total rotation is the negative of the oscillator phase. The result is s·cos on the in-phase output and −s·sin on the quadrature output. Both carry the uncompensated CORDIC gain K ≈ 1.6468. The outputs are two bits wider than the input, and that headroom absorbs the gain.

The block accepts one sample per clock with no resource sharing. Low-pass filtering, decimation and gain correction belong to later blocks.

Top module: `cordic_if_mixer`

## Requirements
- R1: A synchronous reset (`rst` high) clears `outValid`, `outI` and `outQ` to zero and returns the oscillator phase to zero. The first sample accepted after reset is rotated by 0 degrees.
- R2: Each sample accepted with `inValid` high produces exactly one result, with `outValid` high, ITER+1 clocks later (13 with the default). Back-to-back samples give back-to-back results. `outValid` is never high otherwise.
- R3: `outI` equals round(K·s·cos(n·45°)) within ±8 LSB. Here K = 1.64676, s is the signed two's-complement sample and n is the number of samples accepted since reset before this one.
- R4: `outQ` equals round(−K·s·sin(n·45°)) within ±8 LSB, with the same s and n.
- R5: The phase index n advances only on cycles with `inValid` high. Idle cycles leave it unchanged, whatever `inSample` holds.
- R6: The phase index wraps modulo 8, so the ninth accepted sample after reset sees the same phase as the first.
- R7: While `outValid` is low, `outI` and `outQ` hold the value of the last result.
- R8: Full-scale inputs (−2^(SAMPLE_W−1) and 2^(SAMPLE_W−1)−1) never overflow. Every result magnitude stays at or below floor(2^(SAMPLE_W−1)·27/16)+8, which fits in SAMPLE_W+2 signed bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one sample per cycle at most |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Sample strobe: `inSample` is accepted this cycle |
| inSample | input | SAMPLE_W | Signed two's-complement IF sample |
| outValid | output | 1 | Result strobe |
| outI | output | SAMPLE_W+2 | Signed in-phase result, K·s·cos |
| outQ | output | SAMPLE_W+2 | Signed quadrature result, −K·s·sin |

## Verification
The assertions assume that `rst` is held high from time zero until the first clock edges have passed. They also assume that `inSample` is a plain two's-complement value whose magnitude the overflow bound covers: the bound is sized for any SAMPLE_W-bit input, so only the reset assumption narrows the stimulus. The bench raises reset at time zero and again mid-stream, holding it for several cycles each time. It drives full-scale positive and negative samples to reach the overflow bound. It mixes back-to-back strobes with gapped strobes, and changes `inSample` during idle cycles, so that the phase and hold properties are exercised under ignored data.

// File: rtl/cim_pkg.sv
package cim_pkg;

  // Oscillator phase: eight steps of 45 degrees per turn.
  localparam int PHASE_W = 3;
  // Angle word: one full turn equals 2**ANG_W.
  localparam int ANG_W = 16;
  // Largest iteration count the arctangent table covers.
  localparam int MAX_ITER = 16;

  typedef struct packed {
    logic                 load;   // capture a new sample into the first stage
    logic [PHASE_W-1:0]   phase;  // oscillator phase for that sample
  } mix_ctrl_t;

  // atan(2^-idx) as a fraction of a turn, scaled by 2**ANG_W.
  function automatic logic [ANG_W-1:0] atanStep(input int idx);
    case (idx)
      0:       atanStep = 16'd8192;
      1:       atanStep = 16'd4836;
      2:       atanStep = 16'd2555;
      3:       atanStep = 16'd1297;
      4:       atanStep = 16'd651;
      5:       atanStep = 16'd326;
      6:       atanStep = 16'd163;
      7:       atanStep = 16'd81;
      8:       atanStep = 16'd41;
      9:       atanStep = 16'd20;
      10:      atanStep = 16'd10;
      11:      atanStep = 16'd5;
      12:      atanStep = 16'd3;
      13:      atanStep = 16'd1;
      14:      atanStep = 16'd1;
      default: atanStep = 16'd0;
    endcase
  endfunction

endpackage

// File: rtl/cim_ctrl.sv
module cim_ctrl
  import cim_pkg::*;
#(
  parameter int ITER = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  output mix_ctrl_t         ctrl,
  output logic [ITER-1:0]   stageEn,
  output logic              outValid
);

  logic [PHASE_W-1:0] phaseReg;
  logic [ITER:0]      validPipe;

  // The phase counter steps only on accepted samples; it wraps naturally modulo 8.
  always_ff @(posedge clk) begin
    if (rst) begin
      phaseReg  <= '0;
      validPipe <= '0;
    end else begin
      if (inValid) phaseReg <= phaseReg + 1'b1;
      validPipe <= {validPipe[ITER-1:0], inValid};
    end
  end

  assign ctrl.load  = inValid;
  assign ctrl.phase = phaseReg;
  assign stageEn    = validPipe[ITER-1:0];
  assign outValid   = validPipe[ITER];

endmodule

// File: rtl/cim_cordic.sv
module cim_cordic
  import cim_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int ITER     = 12,
  parameter int OUT_W    = SAMPLE_W + 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  mix_ctrl_t                  ctrl,
  input  logic [ITER-1:0]            stageEn,
  input  logic [SAMPLE_W-1:0]        inSample,
  output logic signed [OUT_W-1:0]    outI,
  output logic signed [OUT_W-1:0]    outQ
);

  localparam logic [ANG_W-1:0] QUARTER = ANG_W'(1) << (ANG_W - 2);

  logic signed [OUT_W-1:0] xs [0:ITER];
  logic signed [OUT_W-1:0] ys [0:ITER];
  logic        [ANG_W-1:0] zs [0:ITER-1];

  // Pre-rotation: the target angle is minus the oscillator phase. A negative
  // target is pre-turned by -90 degrees and a non-negative one by +90, so the
  // remaining angle always lies within +/-90 degrees.
  logic signed [OUT_W-1:0] sExt;
  logic        [ANG_W-1:0] theta;
  logic signed [OUT_W-1:0] preY;
  logic        [ANG_W-1:0] preZ;

  assign sExt  = OUT_W'($signed(inSample));
  assign theta = '0 - {ctrl.phase, {(ANG_W-PHASE_W){1'b0}}};

  always_comb begin
    if (theta[ANG_W-1]) begin
      preY = -sExt;
      preZ = theta + QUARTER;
    end else begin
      preY = sExt;
      preZ = theta - QUARTER;
    end
  end

  logic signed [OUT_W-1:0] x0r, y0r;
  logic        [ANG_W-1:0] z0r;

  always_ff @(posedge clk) begin
    if (rst) begin
      x0r <= '0;
      y0r <= '0;
      z0r <= '0;
    end else if (ctrl.load) begin
      x0r <= '0;
      y0r <= preY;
      z0r <= preZ;
    end
  end

  assign xs[0] = x0r;
  assign ys[0] = y0r;
  assign zs[0] = z0r;

  for (genvar i = 0; i < ITER; i++) begin : g_stage
    localparam logic [ANG_W-1:0] STEP = atanStep(i);
    logic signed [OUT_W-1:0] xSh, ySh, xr, yr;
    logic                    dirPos;

    assign xSh    = xs[i] >>> i;
    assign ySh    = ys[i] >>> i;
    assign dirPos = ~zs[i][ANG_W-1];

    always_ff @(posedge clk) begin
      if (rst) begin
        xr <= '0;
        yr <= '0;
      end else if (stageEn[i]) begin
        if (dirPos) begin
          xr <= xs[i] - ySh;
          yr <= ys[i] + xSh;
        end else begin
          xr <= xs[i] + ySh;
          yr <= ys[i] - xSh;
        end
      end
    end

    assign xs[i+1] = xr;
    assign ys[i+1] = yr;

    // The residual angle is only needed up to the last but one stage.
    if (i < ITER - 1) begin : g_angle
      logic [ANG_W-1:0] zr;
      always_ff @(posedge clk) begin
        if (rst)             zr <= '0;
        else if (stageEn[i]) zr <= dirPos ? zs[i] - STEP : zs[i] + STEP;
      end
      assign zs[i+1] = zr;
    end
  end

  assign outI = xs[ITER];
  assign outQ = ys[ITER];

endmodule

// File: rtl/cordic_if_mixer.sv
module cordic_if_mixer
  import cim_pkg::*;
#(
  parameter  int SAMPLE_W = 12,
  parameter  int ITER     = 12,
  localparam int OUT_W    = SAMPLE_W + 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     inValid,
  input  logic [SAMPLE_W-1:0]      inSample,
  output logic                     outValid,
  output logic signed [OUT_W-1:0]  outI,
  output logic signed [OUT_W-1:0]  outQ
);

  mix_ctrl_t          ctrlBus;
  logic [ITER-1:0]    stageEn;
  logic [PHASE_W-1:0] curPhase;

  assign curPhase = ctrlBus.phase;

  cim_ctrl #(.ITER(ITER)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .ctrl     (ctrlBus),
    .stageEn  (stageEn),
    .outValid (outValid)
  );

  cim_cordic #(.SAMPLE_W(SAMPLE_W), .ITER(ITER), .OUT_W(OUT_W)) u_cordic (
    .clk      (clk),
    .rst      (rst),
    .ctrl     (ctrlBus),
    .stageEn  (stageEn),
    .inSample (inSample),
    .outI     (outI),
    .outQ     (outQ)
  );

endmodule

// File: rtl/cim_checker.sv
module cim_checker #(
  parameter int SAMPLE_W = 12,
  parameter int OUT_W    = SAMPLE_W + 2
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     inValid,
  input logic                     outValid,
  input logic signed [OUT_W-1:0]  outI,
  input logic signed [OUT_W-1:0]  outQ,
  input logic [2:0]               phase
);

  localparam int LIMIT = ((1 << (SAMPLE_W - 1)) * 27) / 16 + 8;

  // Samples accepted and not yet returned.
  int pending;
  always_ff @(posedge clk) begin
    if (rst) pending <= 0;
    else     pending <= pending + int'(inValid) - int'(outValid);
  end

  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
    outValid |-> pending > 0); // R2

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!outValid && !$past(rst)) |-> ($stable(outI) && $stable(outQ))); // R7

  AST_NO_OVERFLOW_I: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (int'(outI) <= LIMIT && int'(outI) >= -LIMIT)); // R8

  AST_NO_OVERFLOW_Q: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (int'(outQ) <= LIMIT && int'(outQ) >= -LIMIT)); // R8

  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst)
    inValid |=> phase == 3'($past(phase) + 3'd1)); // R6

  AST_PHASE_IDLE: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> $stable(phase)); // R5

endmodule

bind cordic_if_mixer cim_checker #(.SAMPLE_W(SAMPLE_W), .OUT_W(OUT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .inValid  (inValid),
  .outValid (outValid),
  .outI     (outI),
  .outQ     (outQ),
  .phase    (curPhase)
);

// File: tb/cordic_if_mixer_tb.sv
module cordic_if_mixer_tb;

  localparam int SW  = 12;
  localparam int IT  = 12;
  localparam int OW  = SW + 2;
  localparam int LAT = IT + 1;
  localparam int TOL = 8;
  localparam real KGAIN = 1.6467602581;
  localparam real PI = 3.14159265358979;

  logic                  clk = 1'b0;
  logic                  rst = 1'b1;
  logic                  inValid = 1'b0;
  logic [SW-1:0]         inSample = '0;
  logic                  outValid;
  logic signed [OW-1:0]  outI, outQ;

  cordic_if_mixer #(.SAMPLE_W(SW), .ITER(IT)) u_dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inSample(inSample),
    .outValid(outValid), .outI(outI), .outQ(outQ)
  );

  always #2 clk = ~clk;

  int nChecks = 0;
  int nFails  = 0;
  int cyc     = 0;
  int sampCnt = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int expOf(input int s, input int p, input bit quad);
    real a = p * PI / 4.0;
    real r = quad ? -KGAIN * s * $sin(a) : KGAIN * s * $cos(a);
    return $rtoi(r + ((r >= 0.0) ? 0.5 : -0.5));
  endfunction

  // Expectation queue
  int    qI [0:255];
  int    qQ [0:255];
  int    qC [0:255];
  string qT [0:255];
  int    head = 0;
  int    tail = 0;
  int    lastI = 0;
  int    lastQ = 0;

  // Output monitor, away from the active edge
  always @(negedge clk) begin
    if (rst) begin
      head = tail;
    end else if (outValid) begin
      if (head == tail) begin
        check(1'b0, "R2", "result without accepted sample", 1, 0);
      end else begin
        check(cyc - qC[head] == LAT, "R2", "latency", cyc - qC[head], LAT);
        check((int'(outI) - qI[head]) <= TOL && (qI[head] - int'(outI)) <= TOL,
              {"R3 ", qT[head]}, "outI", int'(outI), qI[head]);
        check((int'(outQ) - qQ[head]) <= TOL && (qQ[head] - int'(outQ)) <= TOL,
              {"R4 ", qT[head]}, "outQ", int'(outQ), qQ[head]);
        head = (head + 1) % 256;
      end
    end else begin
      check(int'(outI) == lastI && int'(outQ) == lastQ, "R7", "hold while idle",
            int'(outI), lastI);
    end
    lastI = int'(outI);
    lastQ = int'(outQ);
  end

  // Drive one cycle; called at a falling edge, returns at the next one.
  task automatic drive(input bit v, input int s, input string tag);
    inValid  = v;
    inSample = s[SW-1:0];
    if (v) begin
      qI[tail] = expOf(s, sampCnt % 8, 1'b0);
      qQ[tail] = expOf(s, sampCnt % 8, 1'b1);
      qC[tail] = cyc;
      qT[tail] = tag;
      tail = (tail + 1) % 256;
      sampCnt++;
    end
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic drain();
    repeat (LAT + 3) drive(1'b0, 0, "");
    check(head == tail, "R2", "all results returned", (tail - head + 256) % 256, 0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    inValid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    sampCnt = 0;
    check(outValid == 1'b0, "R1", "outValid after reset", int'(outValid), 0);
    check(outI == '0 && outQ == '0, "R1", "outputs after reset", int'(outI), 0);
  endtask

  task automatic t_sweep();
    for (int k = 0; k < 8; k++) drive(1'b1, 1000, "phase sweep");
    drain();
  endtask

  task automatic t_gaps();
    int vals [5] = '{-700, 1500, 333, -1234, 2000};
    for (int k = 0; k < 5; k++) begin
      drive(1'b1, vals[k], "R5 gapped");
      for (int g = 0; g <= k % 3; g++) drive(1'b0, 1777, "");
    end
    drain();
  endtask

  task automatic t_wrap();
    for (int k = 0; k < 16; k++)
      drive(1'b1, (k % 2 == 0) ? 2047 : -2048, "R6 R8 full scale wrap");
    drain();
  endtask

  task automatic t_idleHold();
    int holdI = int'(outI);
    int holdQ = int'(outQ);
    for (int k = 0; k < 10; k++) drive(1'b0, k * 300 - 1500, "");
    check(int'(outI) == holdI && int'(outQ) == holdQ, "R7", "outputs after idle data",
          int'(outI), holdI);
    drive(1'b1, -900, "R5 after idle");
    drain();
  endtask

  task automatic t_midReset();
    for (int k = 0; k < 5; k++) drive(1'b1, 1200, "pre-reset");
    repeat (3) drive(1'b0, 0, "");
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    sampCnt = 0;
    for (int k = 0; k < LAT + 2; k++) begin
      check(outValid == 1'b0, "R1", "no stale result after reset", int'(outValid), 0);
      @(negedge clk);
    end
    drive(1'b1, 500, "R1 first sample phase zero");
    drain();
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_sweep();
    t_gaps();
    t_wrap();
    t_idleHold();
    t_midReset();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #(4 * 200000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 200000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule